// File: doc/BRIEF.md
# DMA Channel Error Status Tracker

This block keeps the error state of every channel of a 24-channel DMA controller. It has two sources of events. The first is a vector of per-channel bus-error pulses from the transfer engine. The second is a descriptor-fetch report that carries a channel number and a 3-bit cycle-control field. A fetched descriptor whose cycle-control field is all zeros is invalid.

Software sees three write-one-to-clear views through a small register port:
- a combined view, which records either kind of error;
- a bus-error view;
- an invalid-descriptor view.

Each view has its own flops, so clearing a bit in one view leaves the other views as they are.

Whenever an error event hits a channel, the block sends a one-cycle disable pulse for that channel alone to the channel-enable logic. Clearing a status bit never re-enables a channel.

Top module: `dma_err_tracker`

## Requirements
- R1: After reset, every status bit in all three views is 0, `chan_dis_o` is 0 and `reg_rdata_o` is 0.
- R2: The block samples `reg_addr_i` on every clock edge and shows the selected view on `reg_rdata_o` from that edge on. The views sit at these byte offsets: 0x48 is the combined view, 0x4C is the bus-error view and 0x50 is the invalid-descriptor view. Bit k of a view (k = 0..23) belongs to channel k. Bits [31:24] always read as 0.
- R3: A combined-view bit sets on the clock edge where its channel has `bus_err_i` high. It also sets on the edge where a fetch report is valid for that channel with `fetch_cc_i` = 3'b000.
- R4: A bus-error-view bit sets only from `bus_err_i`. A fetch report never sets it.
- R5: An invalid-descriptor-view bit sets only from a valid fetch report with `fetch_cc_i` = 3'b000. A fetch report with any other cycle-control value changes no view and sends no disable.
- R6: An error event on channel k makes `chan_dis_o[k]` high for exactly the one cycle after the event edge. All other bits of `chan_dis_o` stay 0.
- R7: Suppose `reg_wr_i` is high at one of the three offsets. Each 1 in `reg_wdata_i[23:0]` then clears the matching bit of that view only. Each 0 leaves its bit unchanged.
- R8: If a set event and a write-one-to-clear hit the same bit on the same edge, the bit ends up set.
- R9: Offsets outside the three views read as 0. Writes to those offsets change no view.
- R10: A register write never causes a pulse on `chan_dis_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_err_i | input | 24 | Per-channel bus-error pulses from the transfer engine |
| fetch_vld_i | input | 1 | Descriptor-fetch report valid |
| fetch_ch_i | input | 5 | Channel of the fetch report |
| fetch_cc_i | input | 3 | Cycle-control field of the fetched descriptor |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data; each 1 clears a bit |
| reg_rdata_o | output | 32 | Registered read data |
| chan_dis_o | output | 24 | One-cycle per-channel disable request |

## Verification
Every result of this block appears one clock edge after its stimulus:
- a status bit changes on the edge that samples the event or the write;
- `chan_dis_o` rises on the event edge and falls one edge later;
- `reg_rdata_o` shows the view as it stood just before the edge that sampled the address.

The bench applies every stimulus at a falling edge and queues the expected read word and disable vector for the next cycle. A monitor compares them at the falling edge after the outputs update. This also checks that each disable pulse is only one cycle long, and that the status update and the read are ordered correctly on the same edge.

// File: rtl/dma_err_tracker.sv
module dma_err_tracker #(
  parameter int NCH = 24,
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter int CCW = 3,
  parameter logic [AW-1:0] ERR_OFS = 8'h48,
  parameter logic [AW-1:0] BUS_OFS = 8'h4C,
  parameter logic [AW-1:0] DSC_OFS = 8'h50,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] bus_err_i,
  input  logic           fetch_vld_i,
  input  logic [CHW-1:0] fetch_ch_i,
  input  logic [CCW-1:0] fetch_cc_i,
  input  logic           reg_wr_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic [NCH-1:0] chan_dis_o
);

  logic [NCH-1:0] err_q, bus_q, dsc_q;
  logic [NCH-1:0] dsc_set, err_set;
  logic [NCH-1:0] err_clr, bus_clr, dsc_clr;
  logic [NCH-1:0] rd_sel;
  logic [DW-1:0]  rdata_q;
  logic [NCH-1:0] dis_q;
  logic           unused_wd;

  for (genvar k = 0; k < NCH; k++) begin : g_dsc
    assign dsc_set[k] = fetch_vld_i && (fetch_ch_i == CHW'(k)) && (fetch_cc_i == '0);
  end

  assign err_set = bus_err_i | dsc_set;

  assign err_clr = (reg_wr_i && reg_addr_i == ERR_OFS) ? reg_wdata_i[NCH-1:0] : '0;
  assign bus_clr = (reg_wr_i && reg_addr_i == BUS_OFS) ? reg_wdata_i[NCH-1:0] : '0;
  assign dsc_clr = (reg_wr_i && reg_addr_i == DSC_OFS) ? reg_wdata_i[NCH-1:0] : '0;
  assign unused_wd = ^reg_wdata_i[DW-1:NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0;
      bus_q <= '0;
      dsc_q <= '0;
      dis_q <= '0;
    end else begin
      err_q <= (err_q & ~err_clr) | err_set;
      bus_q <= (bus_q & ~bus_clr) | bus_err_i;
      dsc_q <= (dsc_q & ~dsc_clr) | dsc_set;
      dis_q <= err_set;
    end
  end

  always_comb begin
    case (reg_addr_i)
      ERR_OFS: rd_sel = err_q;
      BUS_OFS: rd_sel = bus_q;
      DSC_OFS: rd_sel = dsc_q;
      default: rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= {{(DW-NCH){1'b0}}, rd_sel};
  end

  assign reg_rdata_o = rdata_q;
  assign chan_dis_o  = dis_q;

endmodule

// File: rtl/dma_err_tracker_chk.sv
module dma_err_tracker_chk #(
  parameter int NCH = 24,
  parameter int DW  = 32,
  parameter int CCW = 3,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] bus_err_i,
  input logic           fetch_vld_i,
  input logic [CHW-1:0] fetch_ch_i,
  input logic [CCW-1:0] fetch_cc_i,
  input logic           reg_wr_i,
  input logic [DW-1:0]  reg_rdata_o,
  input logic [NCH-1:0] chan_dis_o,
  input logic [NCH-1:0] err_q,
  input logic [NCH-1:0] bus_q,
  input logic [NCH-1:0] dsc_q
);

  logic [NCH-1:0] bad_v;
  always_comb begin
    bad_v = '0;
    if (fetch_vld_i && fetch_cc_i == '0 && int'(fetch_ch_i) < NCH) bad_v[fetch_ch_i] = 1'b1;
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[DW-1:NCH] == '0);

  // R4
  bus_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_q & $past(bus_err_i)) == $past(bus_err_i));

  // R4
  bus_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_q & ~$past(bus_q) & ~$past(bus_err_i)) == '0);

  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_q & $past(bus_err_i | bad_v)) == $past(bus_err_i | bad_v));

  // R5
  dsc_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dsc_q & ~$past(dsc_q) & ~$past(bad_v)) == '0);

  // R6
  dis_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> chan_dis_o == $past(bus_err_i | bad_v));

  // R7
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> ((~err_q & $past(err_q)) | (~bus_q & $past(bus_q)) | (~dsc_q & $past(dsc_q))) == '0);

endmodule

bind dma_err_tracker dma_err_tracker_chk #(.NCH(NCH), .DW(DW), .CCW(CCW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_err_i(bus_err_i), .fetch_vld_i(fetch_vld_i),
  .fetch_ch_i(fetch_ch_i), .fetch_cc_i(fetch_cc_i), .reg_wr_i(reg_wr_i),
  .reg_rdata_o(reg_rdata_o), .chan_dis_o(chan_dis_o),
  .err_q(err_q), .bus_q(bus_q), .dsc_q(dsc_q)
);

// File: tb/test_dma_err_tracker.sv
module test_dma_err_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_err_i = '0;
  logic        fetch_vld_i = 1'b0;
  logic [4:0]  fetch_ch_i = '0;
  logic [2:0]  fetch_cc_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [23:0] chan_dis_o;

  dma_err_tracker i_dma_err_tracker (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_dis;
    logic [31:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic [23:0] m_err = '0, m_bus = '0, m_dsc = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_dis ? {8'h0, chan_dis_o} : reg_rdata_o;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", it.tag, it.is_dis ? "dis" : "rdata", act, it.exp);
      end
    end
  end

  function automatic logic [31:0] view(input logic [7:0] a);
    case (a)
      8'h48:   return {8'h0, m_err};
      8'h4C:   return {8'h0, m_bus};
      8'h50:   return {8'h0, m_dsc};
      default: return '0;
    endcase
  endfunction

  task automatic step(input logic [23:0] be, input bit fv, input int ch, input logic [2:0] cc,
                      input bit wr, input logic [7:0] a, input logic [31:0] wd, input string tag);
    logic [23:0] inv, clr;
    item_t it;
    @(negedge clk);
    bus_err_i = be; fetch_vld_i = fv; fetch_ch_i = 5'(ch); fetch_cc_i = cc;
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
    inv = '0;
    if (fv && cc == 3'b000 && ch < 24) inv[ch] = 1'b1;
    it.is_dis = 1'b0; it.exp = view(a); it.due = cyc + 1; it.tag = tag; q.push_back(it);
    it.is_dis = 1'b1; it.exp = {8'h0, be | inv}; q.push_back(it);
    clr = wr ? wd[23:0] : '0;
    m_err = (m_err & ~((a == 8'h48) ? clr : 24'h0)) | be | inv;
    m_bus = (m_bus & ~((a == 8'h4C) ? clr : 24'h0)) | be;
    m_dsc = (m_dsc & ~((a == 8'h50) ? clr : 24'h0)) | inv;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step('0, 0, 0, 3'b111, 0, a, '0, tag);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
      begin
        repeat (3) @(posedge clk);
        checks++;
        if (reg_rdata_o !== 32'h0 || chan_dis_o !== 24'h0) begin
          errors++;
          $display("FAIL R1 actual=%h/%h expected=0/0", reg_rdata_o, chan_dis_o);
        end
        @(negedge clk); rst_n = 1'b1;
        rd(8'h48, "R1"); rd(8'h4C, "R1"); rd(8'h50, "R1");
        step(24'h000008, 0, 0, 3'b111, 0, 8'h48, '0, "R6");
        rd(8'h48, "R3"); rd(8'h4C, "R4"); rd(8'h50, "R5");
        step('0, 1, 23, 3'b000, 0, 8'h4C, '0, "R6");
        rd(8'h48, "R3"); rd(8'h4C, "R4"); rd(8'h50, "R2");
        step('0, 1, 5, 3'b101, 0, 8'h50, '0, "R5");
        rd(8'h48, "R5"); rd(8'h50, "R5");
        step('0, 0, 0, 3'b111, 1, 8'h4C, 32'h0, "R7");
        rd(8'h4C, "R7");
        step('0, 0, 0, 3'b111, 1, 8'h4C, 32'h8, "R10");
        rd(8'h4C, "R7"); rd(8'h48, "R7"); rd(8'h50, "R7");
        step(24'h000080, 0, 0, 3'b111, 1, 8'h4C, 32'h80, "R8");
        rd(8'h4C, "R8");
        step('0, 1, 9, 3'b000, 1, 8'h50, 32'h200, "R8");
        rd(8'h50, "R8");
        step('0, 0, 0, 3'b111, 1, 8'h54, 32'hFFFFFFFF, "R9");
        rd(8'h54, "R9"); rd(8'h00, "R9");
        rd(8'h48, "R9"); rd(8'h4C, "R9"); rd(8'h50, "R9");
        step(24'h800001, 0, 0, 3'b111, 0, 8'h48, '0, "R6");
        step('0, 0, 0, 3'b111, 1, 8'h48, 32'hFFFFFFFF, "R10");
        rd(8'h48, "R2"); rd(8'h4C, "R7"); rd(8'h50, "R7");
        rd(8'h4C, "R2");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
          errors++;
          $display("FAIL scoreboard actual=%0d expected=0 pending", q.size());
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule